// File: doc/BRIEF.md
# Fault capture register with one-shot machine-error request

This block gathers active-low fault lines from around the processor into a sticky fault register. The register is sampled on each rising edge of the block clock. When a fault is captured while the request path is armed, the block sends a single one-cycle pulse that sets the machine-error pending level (level 1) in the interrupt controller. It then disarms itself. Acknowledging the interrupt does not clear the fault bits, so the disarm is what stops the same faults from raising level 1 again and again. Software re-arms the path by clearing the register, or by loading it with zero.

Three fault positions (0, 5 and 8; position 8 is the bus-timeout fault) belong to the abort class. When such a fault is newly latched, the block pulses an instruction-abort output for one cycle. While a DMA transfer or a bus hold is in progress, abort-class faults are not captured at all. A 3-bit command code gives access from software: load the register from the data bus, clear it, read it without side effects, or put the priority vector supplied by the interrupt controller onto the data bus.

Top module: `fault_capture_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the fault register clears, the request path is armed, and lvl1_req and abort_pulse are 0 after that edge. data_oe is 0 while cmd is 000.
- R2: A 0 on fault_n[i] at a clock edge sets register bit i. The bit stays set after the input returns to 1, until a load or clear command.
- R3: If the path is armed and the register is non-zero after an edge, lvl1_req is 1 for the cycle that follows that edge, and the path disarms.
- R4: While the path is disarmed and no load or clear command occurs, further captures leave lvl1_req at 0.
- R5: Command 110 (clear) zeroes the register and re-arms the path. A fault that is low during the clear edge is still captured, and it raises a new request.
- R6: Command 001 (load) writes data_in[8:0] into the register. A load that leaves the register non-zero while armed raises a request. A load of zero re-arms the path.
- R7: Command 111 (read fault) drives data_out with the register, zero-extended to 16 bits, and drives data_oe to 1. The register is not changed.
- R8: Command 010 (read vector) drives data_out with prio_vec, zero-extended, and drives data_oe to 1.
- R9: abort_pulse is 1 for exactly the one cycle after an edge at which bit 0, 5 or 8 goes from clear to set by capture. It is never 1 for other bits, or for a bit that is already held.
- R10: While dma_busy or bus_hold is 1, bits 0, 5 and 8 are not captured. The other bits are captured as usual.
- R11: Codes 000, 011, 100 and 101 leave the register unchanged. With these codes, data_oe is 0 and data_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; captures on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_n | input | 9 | Active-low fault lines; bit 8 is the bus-timeout fault |
| dma_busy | input | 1 | High during a DMA transfer |
| bus_hold | input | 1 | High while the bus is held |
| cmd | input | 3 | Command code: 001 load, 010 read vector, 110 clear, 111 read fault |
| data_in | input | 16 | Write data for the load command |
| prio_vec | input | 4 | Priority vector from the interrupt controller |
| data_out | output | 16 | Read data; 0 when not reading |
| data_oe | output | 1 | High while a read command drives data_out |
| lvl1_req | output | 1 | One-cycle set pulse for pending level 1 |
| abort_pulse | output | 1 | One-cycle instruction-abort pulse |

## Verification
A wrong arm flag shows up at lvl1_req one edge after the next capture or command. If the flag is stuck disarmed, no request follows a clear and a new fault. If it is stuck armed, a second pulse follows a capture that should have been blocked. A wrong register bit shows on data_out in the same cycle that a read command is presented, and on abort_pulse at the next abort-class capture. A reference model is therefore compared on every clock, while reads are interleaved with captures, commands and DMA/hold windows.

// File: rtl/fcu_pkg.sv
// Package: command codes and shared constants for the fault capture unit.
// Assumes a 3-bit command field; codes not listed here have no effect on this block.
package fcu_pkg;
    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE  = 3'b000,
        CMD_LOAD  = 3'b001,
        CMD_RDVEC = 3'b010,
        CMD_CLEAR = 3'b110,
        CMD_RDFLT = 3'b111
    } fcu_cmd_e;
endpackage

// File: rtl/fcu_cmd_decode.sv
// Command decoder: turns the raw command code into one-hot action strobes.
// Assumes cmd is valid for the whole cycle; unknown codes produce no strobe.
module fcu_cmd_decode
    import fcu_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output logic             do_load,
    output logic             do_clear,
    output logic             do_rd_flt,
    output logic             do_rd_vec
);
    // Purpose: map each recognised code to its strobe.
    always_comb begin
        do_load   = 1'b0;
        do_clear  = 1'b0;
        do_rd_flt = 1'b0;
        do_rd_vec = 1'b0;
        case (cmd)
            CMD_LOAD:  do_load   = 1'b1;
            CMD_CLEAR: do_clear  = 1'b1;
            CMD_RDFLT: do_rd_flt = 1'b1;
            CMD_RDVEC: do_rd_vec = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/fcu_fault_latch.sv
// Fault latch: sticky fault register with per-bit suppression of abort-class
// faults during DMA/hold, and a one-cycle abort pulse on a fresh abort-class capture.
// Assumes fault_n is already synchronous to clk.
module fcu_fault_latch #(
    parameter int                    NUM_FAULTS = 9,
    parameter logic [NUM_FAULTS-1:0] ABORT_MASK = 9'h121
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_n,
    input  logic                  suppress,
    input  logic                  do_load,
    input  logic                  do_clear,
    input  logic [NUM_FAULTS-1:0] load_val,
    output logic [NUM_FAULTS-1:0] fault_q,
    output logic                  base_zero,
    output logic                  next_nonzero,
    output logic                  abort_pulse
);
    logic [NUM_FAULTS-1:0] cap;
    logic [NUM_FAULTS-1:0] base;
    logic [NUM_FAULTS-1:0] fault_d;
    logic                  abort_d;

    // Purpose: per-bit capture, blocking abort-class bits while suppressed.
    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_cap
        if (ABORT_MASK[i]) begin : g_abort_bit
            assign cap[i] = ~fault_n[i] & ~suppress;
        end else begin : g_plain_bit
            assign cap[i] = ~fault_n[i];
        end
    end

    // Purpose: choose the register base (command value or held state) and merge captures.
    always_comb begin
        if (do_load)       base = load_val;
        else if (do_clear) base = '0;
        else               base = fault_q;
        fault_d      = base | cap;
        base_zero    = (base == '0);
        next_nonzero = (fault_d != '0);
        abort_d      = |(cap & ~base & ABORT_MASK);
    end

    // Purpose: hold the fault register and the registered abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q     <= '0;
            abort_pulse <= 1'b0;
        end else begin
            fault_q     <= fault_d;
            abort_pulse <= abort_d;
        end
    end
endmodule

// File: rtl/fcu_rearm.sv
// Re-arm control: issues one level-1 request per arming, and disarms until a
// clear or load command leaves the fault register empty.
// Assumes base_zero/next_nonzero come from the fault latch for the same cycle.
module fcu_rearm (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_write,
    input  logic base_zero,
    input  logic next_nonzero,
    output logic lvl1_req
);
    logic blocked_q;
    logic blocked_eff;
    logic fire;

    // Purpose: apply re-arm from an emptying command, then decide whether to fire.
    always_comb begin
        blocked_eff = (reg_write && base_zero) ? 1'b0 : blocked_q;
        fire        = next_nonzero && !blocked_eff;
    end

    // Purpose: register the disarm flag and the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q <= 1'b0;
            lvl1_req  <= 1'b0;
        end else begin
            blocked_q <= blocked_eff | fire;
            lvl1_req  <= fire;
        end
    end
endmodule

// File: rtl/fault_capture_unit.sv
// Fault capture unit top: joins the decoder, fault latch and re-arm control,
// and muxes read data onto the data bus.
// Assumes DATA_W exceeds NUM_FAULTS and VEC_W; read data is combinational from cmd.
module fault_capture_unit
    import fcu_pkg::*;
#(
    parameter int                    NUM_FAULTS = 9,
    parameter int                    DATA_W     = 16,
    parameter int                    VEC_W      = 4,
    parameter logic [NUM_FAULTS-1:0] ABORT_MASK = 9'h121
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_n,
    input  logic                  dma_busy,
    input  logic                  bus_hold,
    input  logic [CMD_W-1:0]      cmd,
    input  logic [DATA_W-1:0]     data_in,
    input  logic [VEC_W-1:0]      prio_vec,
    output logic [DATA_W-1:0]     data_out,
    output logic                  data_oe,
    output logic                  lvl1_req,
    output logic                  abort_pulse
);
    localparam int FLT_PAD = DATA_W - NUM_FAULTS;
    localparam int VEC_PAD = DATA_W - VEC_W;

    logic                  do_load, do_clear, do_rd_flt, do_rd_vec;
    logic [NUM_FAULTS-1:0] fault_q;
    logic                  base_zero, next_nonzero;
    logic                  unused_data_hi;

    assign unused_data_hi = ^data_in[DATA_W-1:NUM_FAULTS];

    fcu_cmd_decode u_dec (
        .cmd       (cmd),
        .do_load   (do_load),
        .do_clear  (do_clear),
        .do_rd_flt (do_rd_flt),
        .do_rd_vec (do_rd_vec)
    );

    fcu_fault_latch #(
        .NUM_FAULTS (NUM_FAULTS),
        .ABORT_MASK (ABORT_MASK)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_n      (fault_n),
        .suppress     (dma_busy | bus_hold),
        .do_load      (do_load),
        .do_clear     (do_clear),
        .load_val     (data_in[NUM_FAULTS-1:0]),
        .fault_q      (fault_q),
        .base_zero    (base_zero),
        .next_nonzero (next_nonzero),
        .abort_pulse  (abort_pulse)
    );

    fcu_rearm u_rearm (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_write    (do_load | do_clear),
        .base_zero    (base_zero),
        .next_nonzero (next_nonzero),
        .lvl1_req     (lvl1_req)
    );

    // Purpose: select read data for the bus; zero when no read is active.
    always_comb begin
        data_out = '0;
        if (do_rd_flt)      data_out = {{FLT_PAD{1'b0}}, fault_q};
        else if (do_rd_vec) data_out = {{VEC_PAD{1'b0}}, prio_vec};
        data_oe = do_rd_flt | do_rd_vec;
    end
endmodule

// File: rtl/fcu_checker.sv
// Checker for the fault capture unit: temporal properties on ports and the
// fault register, attached to the top module by bind.
module fcu_checker #(
    parameter int                    NUM_FAULTS = 9,
    parameter int                    DATA_W     = 16,
    parameter logic [NUM_FAULTS-1:0] ABORT_MASK = 9'h121
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            cmd,
    input logic                  dma_busy,
    input logic                  bus_hold,
    input logic [NUM_FAULTS-1:0] fault_q,
    input logic [DATA_W-1:0]     data_out,
    input logic                  data_oe,
    input logic                  lvl1_req,
    input logic                  abort_pulse
);
    logic reg_cmd;
    assign reg_cmd = (cmd == 3'b001) || (cmd == 3'b110);

    p_req_has_faults_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl1_req |-> (fault_q != '0));

    p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl1_req && !reg_cmd) |=> !lvl1_req);

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_cmd |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

    p_abort_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> ((fault_q & ABORT_MASK) != '0));

    p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_busy || bus_hold) && cmd != 3'b001)
            |=> ((fault_q & ~$past(fault_q) & ABORT_MASK) == '0));

    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));
endmodule

bind fault_capture_unit fcu_checker #(
    .NUM_FAULTS (NUM_FAULTS),
    .DATA_W     (DATA_W),
    .ABORT_MASK (ABORT_MASK)
) u_fcu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .dma_busy    (dma_busy),
    .bus_hold    (bus_hold),
    .fault_q     (fault_q),
    .data_out    (data_out),
    .data_oe     (data_oe),
    .lvl1_req    (lvl1_req),
    .abort_pulse (abort_pulse)
);

// File: tb/tb_fault_capture_unit.sv
module tb_fault_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  fault_n = 9'h1FF;
    logic        dma_busy = 1'b0;
    logic        bus_hold = 1'b0;
    logic [2:0]  cmd = 3'b000;
    logic [15:0] data_in = 16'h0;
    logic [3:0]  prio_vec = 4'h0;
    logic [15:0] data_out;
    logic        data_oe, lvl1_req, abort_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [8:0] m_reg = 9'h0;
    bit         m_blk = 0, m_req = 0, m_abt = 0;
    localparam logic [8:0] AMASK = 9'h121;

    fault_capture_unit dut (
        .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .dma_busy(dma_busy),
        .bus_hold(bus_hold), .cmd(cmd), .data_in(data_in), .prio_vec(prio_vec),
        .data_out(data_out), .data_oe(data_oe), .lvl1_req(lvl1_req),
        .abort_pulse(abort_pulse)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [8:0] cap, base, nreg;
        bit blk2;
        if (!rst_n) begin
            m_reg = 0; m_blk = 0; m_req = 0; m_abt = 0;
        end else begin
            cap = ~fault_n;
            if (dma_busy || bus_hold) cap = cap & ~AMASK;
            if (cmd == 3'b001)      base = data_in[8:0];
            else if (cmd == 3'b110) base = 9'h0;
            else                    base = m_reg;
            blk2  = ((cmd == 3'b001 || cmd == 3'b110) && base == 0) ? 0 : m_blk;
            nreg  = base | cap;
            m_req = (nreg != 0) && !blk2;
            m_abt = ((cap & ~base & AMASK) != 0);
            m_blk = blk2 | m_req;
            m_reg = nreg;
        end
    endtask

    task automatic compare_all();
        int exp_data;
        bit exp_oe;
        exp_oe = (cmd == 3'b111) || (cmd == 3'b010);
        exp_data = (cmd == 3'b111) ? int'(m_reg) : (cmd == 3'b010) ? int'(prio_vec) : 0;
        chk("R3 lvl1_req model", lvl1_req, m_req);
        chk("R9 abort_pulse model", abort_pulse, m_abt);
        chk("R7 data_out model", data_out, exp_data);
        chk("R7 data_oe model", data_oe, exp_oe);
    endtask

    task automatic step(input logic [2:0] c, input logic [15:0] d,
                        input logic [8:0] fn, input logic dm, input logic hd);
        cmd = c; data_in = d; fault_n = fn; dma_busy = dm; bus_hold = hd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [8:0] low(input int i);
        return ~(9'h1 << i);
    endfunction

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(3'b000, 16'h0, 9'h000, 1'b0, 1'b0);
        chk("R1 lvl1_req reset", lvl1_req, 0);
        chk("R1 abort reset", abort_pulse, 0);
        chk("R1 data_oe reset", data_oe, 0);
        rst_n = 1'b1;
        step(3'b111, 16'h0, 9'h1FF, 0, 0);
        chk("R1 register empty after reset", data_out, 16'h0000);

        step(3'b000, 16'h0, low(2), 0, 0);
        chk("R3 first capture requests", lvl1_req, 1);
        chk("R9 no abort for bit 2", abort_pulse, 0);
        step(3'b000, 16'h0, 9'h1FF, 0, 0);
        chk("R3 request lasts one cycle", lvl1_req, 0);
        step(3'b111, 16'h0, 9'h1FF, 0, 0);
        chk("R2 bit sticky after release", data_out, 16'h0004);
        chk("R7 read enables bus", data_oe, 1);
        step(3'b000, 16'h0, low(3), 0, 0);
        chk("R4 no second request", lvl1_req, 0);
        step(3'b111, 16'h0, 9'h1FF, 0, 0);
        chk("R2 accumulated bits", data_out, 16'h000C);
        step(3'b111, 16'h0, 9'h1FF, 0, 0);
        chk("R7 read leaves register", data_out, 16'h000C);

        step(3'b110, 16'h0, 9'h1FF, 0, 0);
        chk("R5 clear to empty gives no request", lvl1_req, 0);
        step(3'b111, 16'h0, 9'h1FF, 0, 0);
        chk("R5 register cleared", data_out, 16'h0000);
        step(3'b000, 16'h0, low(4), 0, 0);
        chk("R5 re-armed request", lvl1_req, 1);

        step(3'b000, 16'h0, low(5), 0, 0);
        chk("R9 abort on bit 5", abort_pulse, 1);
        chk("R4 still blocked", lvl1_req, 0);
        step(3'b000, 16'h0, low(5), 0, 0);
        chk("R9 abort not repeated while held", abort_pulse, 0);
        step(3'b111, 16'h0, low(5), 0, 0);
        chk("R7 read shows bits 4 and 5", data_out, 16'h0030);

        step(3'b110, 16'h0, 9'h1FF, 0, 0);
        step(3'b000, 16'h0, 9'h1FF & low(0) & low(8) & low(1), 1, 0);
        chk("R10 non-abort bit captured under DMA", lvl1_req, 1);
        chk("R10 no abort under DMA", abort_pulse, 0);
        step(3'b111, 16'h0, 9'h1FF & low(0) & low(8) & low(1), 0, 1);
        chk("R10 bits 0 and 8 dropped under hold", data_out, 16'h0002);
        chk("R10 no abort under hold", abort_pulse, 0);

        step(3'b110, 16'h0, 9'h1FF, 0, 0);
        step(3'b001, 16'hF0A5, 9'h1FF, 0, 0);
        chk("R6 load non-zero requests", lvl1_req, 1);
        chk("R6 load gives no abort", abort_pulse, 0);
        step(3'b111, 16'h0, 9'h1FF, 0, 0);
        chk("R6 loaded low bits", data_out, 16'h00A5);
        step(3'b001, 16'h0000, 9'h1FF, 0, 0);
        chk("R6 load zero no request", lvl1_req, 0);
        step(3'b001, 16'h0010, 9'h1FF, 0, 0);
        chk("R6 load after re-arm requests", lvl1_req, 1);

        prio_vec = 4'hB;
        step(3'b010, 16'h0, 9'h1FF, 0, 0);
        chk("R8 vector on bus", data_out, 16'h000B);
        chk("R8 bus enabled", data_oe, 1);

        step(3'b011, 16'h01FF, 9'h1FF, 0, 0);
        chk("R11 code 011 no bus", data_oe, 0);
        chk("R11 code 011 data zero", data_out, 0);
        step(3'b100, 16'h01FF, 9'h1FF, 0, 0);
        step(3'b101, 16'h0000, 9'h1FF, 0, 0);
        step(3'b000, 16'h0000, 9'h1FF, 0, 0);
        step(3'b111, 16'h0, 9'h1FF, 0, 0);
        chk("R11 register unchanged by other codes", data_out, 16'h0010);

        step(3'b110, 16'h0, low(0), 0, 0);
        chk("R5 capture during clear requests", lvl1_req, 1);
        chk("R9 abort on bit 0 during clear", abort_pulse, 1);
        step(3'b111, 16'h0, 9'h1FF, 0, 0);
        chk("R5 bit kept through clear edge", data_out, 16'h0001);

        begin
            logic [15:0] lf = 16'hACE1;
            for (int n = 0; n < 400; n++) begin
                logic [2:0] c;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                c = (lf[3:0] == 4'h0) ? 3'b110 : (lf[3:0] == 4'h1) ? 3'b001 :
                    lf[4] ? 3'b111 : lf[2:0];
                prio_vec = lf[15:12];
                step(c, {lf[7:0], lf[15:8]},
                     9'h1FF & ~((lf[11:9] == 3'b000) ? (9'h1 << lf[8:5] % 9) : 9'h0),
                     lf[13] & lf[14], lf[6] & lf[2]);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule